// File: doc/BRIEF.md
# Multiprocessor-Capable Asynchronous Serial Receiver

This block turns an asynchronous NRZ serial line into received characters for a CPU. The line is sampled on a 16x oversampling tick supplied from outside. The receiver detects the falling edge of a start bit and confirms it half a bit later. It then takes every following bit at its centre sample and assembles the data least significant bit first. The finished character, its error status and a data-ready flag are presented on a simple register-style interface.

There are two frame formats. The normal format carries 7 or 8 data bits with an optional parity bit, which can be even or odd. The multiprocessor format always carries 8 data bits followed by an address/data marker bit. That marker takes the place of parity and is reported next to the received byte. Error flags for the frame are posted one cycle before the ready flag rises, so software that sees the ready flag always sees the matching error status. A receive interrupt request follows the ready flag when it is enabled.

Top module: `uart_mp_rx`

## Requirements
- R1: With `rx_enable` high and one `sample_tick` per clock, a frame is a low start bit, the data bits least significant first, then a high stop bit, each bit lasting 16 ticks. The received byte appears on `rx_data` when `rx_ready` rises.
- R2: A low pulse that is no longer high-free than a quarter bit, and that has gone high again by the middle of the start bit, is discarded. No character is produced from it.
- R3: In normal mode, `data_len8`=1 selects 8 data bits and `data_len8`=0 selects 7. A 7-bit character is presented with `rx_data[7]`=0.
- R4: In normal mode with `parity_en`=1, one parity bit follows the data. `parity_err` is set when the data ones plus the parity bit give an odd total with `parity_odd`=0, or an even total with `parity_odd`=1.
- R5: With `mp_mode`=1, 8 data bits are received whatever `data_len8` is. A ninth marker bit follows and is presented on `rx_adbit`. `parity_en` is ignored and `parity_err` is never set. With `mp_mode`=0, `rx_adbit` reads 0.
- R6: A stop bit sampled low sets `frame_err`. The receiver then waits for the line to return high before it looks for a new start bit.
- R7: A frame's error flags become visible one clock before `rx_ready` rises for that frame.
- R8: A one-cycle `data_read` pulse clears `rx_ready` and leaves the error flags unchanged.
- R9: When a frame completes while `rx_ready` is still set, `overrun_err` is set and `rx_data` is overwritten with the new character.
- R10: A one-cycle `err_clear` pulse clears `parity_err`, `frame_err` and `overrun_err`. The error flags are sticky until that pulse.
- R11: `rx_irq` is high exactly while `rx_ready` and `rx_irq_en` are both high.
- R12: While `rx_enable` is low, the receiver stays idle, and a frame sent on the line produces no character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_tick | input | 1 | Oversampling tick, 16 per bit time |
| rx_line | input | 1 | Serial input line, idle high |
| rx_enable | input | 1 | Receiver enable |
| mp_mode | input | 1 | 1 = multiprocessor format |
| data_len8 | input | 1 | Normal mode: 1 = 8 data bits, 0 = 7 |
| parity_en | input | 1 | Normal mode: parity bit present |
| parity_odd | input | 1 | 1 = odd parity, 0 = even |
| rx_irq_en | input | 1 | Receive interrupt enable |
| data_read | input | 1 | Strobe: received data register read |
| err_clear | input | 1 | Strobe: clear all error flags |
| rx_data | output | 8 | Last received character |
| rx_adbit | output | 1 | Address/data marker of last character |
| rx_ready | output | 1 | Received data ready |
| parity_err | output | 1 | Parity error flag |
| frame_err | output | 1 | Framing error flag |
| overrun_err | output | 1 | Overrun error flag |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The hardest case to reach from the ports is the one-cycle ordering between an error flag and the ready flag. Both settle long before any end-of-frame check, so a plain check after the frame cannot tell them apart. The bench therefore watches both flags at every clock during an erroneous frame. At the cycle where `rx_ready` first rises, it checks that the error flag was already high in the cycle before. Overrun is reached by sending two frames without a read between them. The false start is reached by a short low glitch that has gone high again by the middle of the start bit.

// File: rtl/uart_rx_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the multiprocessor-capable serial receiver.
// Assumes: nothing beyond IEEE 1800-2017.
package uart_rx_pkg;
    // Receive bit-timing state machine states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_BREAK
    } rx_state_e;
endpackage

// File: rtl/uart_rx_sampler.sv
`timescale 1ns/1ps
// Module: uart_rx_sampler
// Finds start bits and confirms them at mid-bit. Takes each following bit at
// its centre sample and reports each bit and the end of the frame as
// single-cycle pulses.
// Assumes: rx_s is already synchronised; sample_tick is OVS times the bit rate;
// nbits (data + marker/parity bits) stays stable during a frame.
module uart_rx_sampler #(
    parameter int OVS   = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_tick,
    input  logic             rx_s,
    input  logic             enable,
    input  logic [IDX_W-1:0] nbits,
    output logic             bit_stb,
    output logic             bit_val,
    output logic [IDX_W-1:0] bit_pos,
    output logic             frame_done,
    output logic             stop_ok,
    output logic             busy
);
    import uart_rx_pkg::*;

    localparam int CNT_W = $clog2(OVS);
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS/2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

    rx_state_e        state;
    logic [CNT_W-1:0] tcnt;
    logic [IDX_W-1:0] idx;

    // Bit-timing state machine with tick counter and bit index.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state      <= ST_IDLE;
            tcnt       <= '0;
            idx        <= '0;
            bit_stb    <= 1'b0;
            bit_val    <= 1'b0;
            bit_pos    <= '0;
            frame_done <= 1'b0;
            stop_ok    <= 1'b0;
        end else begin
            bit_stb    <= 1'b0;
            frame_done <= 1'b0;
            if (sample_tick) begin
                unique case (state)
                    ST_IDLE: begin
                        tcnt <= '0;
                        if (!rx_s) state <= ST_START;
                    end
                    ST_START: begin
                        if (tcnt == MID) begin
                            tcnt  <= '0;
                            idx   <= '0;
                            state <= rx_s ? ST_IDLE : ST_DATA;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        tcnt <= tcnt + 1'b1;
                        if (tcnt == LAST) begin
                            bit_stb <= 1'b1;
                            bit_val <= rx_s;
                            bit_pos <= idx;
                            idx     <= idx + 1'b1;
                            if (idx == nbits - 1'b1) state <= ST_STOP;
                        end
                    end
                    ST_STOP: begin
                        tcnt <= tcnt + 1'b1;
                        if (tcnt == LAST) begin
                            frame_done <= 1'b1;
                            stop_ok    <= rx_s;
                            state      <= rx_s ? ST_IDLE : ST_BREAK;
                        end
                    end
                    ST_BREAK: begin
                        if (rx_s) state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Busy whenever a frame or a low-line wait is in progress.
    always_comb busy = (state != ST_IDLE);
endmodule

// File: rtl/uart_rx_assembler.sv
`timescale 1ns/1ps
// Module: uart_rx_assembler
// Collects the sampled bits into a shift store. Splits the store into the
// character and the trailing marker/parity bit, and evaluates parity.
// Assumes: bit positions arrive in order from 0; format inputs stay stable
// during a frame.
module uart_rx_assembler #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              bit_val,
    input  logic [IDX_W-1:0]  bit_pos,
    input  logic              short_len,
    input  logic              parity_odd,
    output logic [DATA_W-1:0] char_data,
    output logic              char_extra,
    output logic              parity_bad
);
    localparam int STORE_W = DATA_W + 1;

    logic [STORE_W-1:0] store;
    logic [IDX_W-1:0]   ndata;

    // Write each sampled bit into its position in the store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store <= '0;
        end else if (bit_stb && (int'(bit_pos) < STORE_W)) begin
            store[bit_pos] <= bit_val;
        end
    end

    // Split the store into character and trailing bit, and check parity.
    always_comb begin
        ndata = short_len ? IDX_W'(DATA_W - 1) : IDX_W'(DATA_W);
        for (int i = 0; i < DATA_W; i++) begin
            char_data[i] = (i < int'(ndata)) ? store[i] : 1'b0;
        end
        char_extra = store[ndata];
        parity_bad = (^char_data) ^ char_extra ^ parity_odd;
    end
endmodule

// File: rtl/uart_rx_status.sv
`timescale 1ns/1ps
// Module: uart_rx_status
// Holds the received character, the sticky error flags, the ready flag and
// the interrupt request. Errors post on frame completion and ready posts one
// cycle later.
// Assumes: frame_done pulses are at least two cycles apart.
module uart_rx_status #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done,
    input  logic              stop_ok,
    input  logic [DATA_W-1:0] char_data,
    input  logic              char_extra,
    input  logic              parity_bad,
    input  logic              mp_mode,
    input  logic              parity_en,
    input  logic              data_read,
    input  logic              err_clear,
    input  logic              irq_en,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_adbit,
    output logic              rx_ready,
    output logic              parity_err,
    output logic              frame_err,
    output logic              overrun_err,
    output logic              rx_irq,
    output logic              ready_pend
);
    // Latch the character and post the error flags on frame completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data     <= '0;
            rx_adbit    <= 1'b0;
            parity_err  <= 1'b0;
            frame_err   <= 1'b0;
            overrun_err <= 1'b0;
        end else if (frame_done) begin
            rx_data     <= char_data;
            rx_adbit    <= mp_mode & char_extra;
            parity_err  <= parity_err | (!mp_mode && parity_en && parity_bad);
            frame_err   <= frame_err | !stop_ok;
            overrun_err <= overrun_err | (rx_ready && !data_read);
        end else if (err_clear) begin
            parity_err  <= 1'b0;
            frame_err   <= 1'b0;
            overrun_err <= 1'b0;
        end
    end

    // Raise ready one cycle after the errors; a read clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_pend <= 1'b0;
            rx_ready   <= 1'b0;
        end else begin
            ready_pend <= frame_done;
            if (ready_pend)     rx_ready <= 1'b1;
            else if (data_read) rx_ready <= 1'b0;
        end
    end

    // Interrupt request follows ready when enabled.
    always_comb rx_irq = rx_ready & irq_en;
endmodule

// File: rtl/uart_mp_rx.sv
`timescale 1ns/1ps
// Module: uart_mp_rx (top)
// Asynchronous serial receiver with a normal format (7/8 data bits and
// optional parity) and a multiprocessor format (8 data bits and a marker bit).
// Assumes: sample_tick runs at OVS times the bit rate; format inputs change
// only while no frame is in progress.
module uart_mp_rx #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_tick,
    input  logic              rx_line,
    input  logic              rx_enable,
    input  logic              mp_mode,
    input  logic              data_len8,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic              rx_irq_en,
    input  logic              data_read,
    input  logic              err_clear,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_adbit,
    output logic              rx_ready,
    output logic              parity_err,
    output logic              frame_err,
    output logic              overrun_err,
    output logic              rx_irq
);
    localparam int IDX_W = $clog2(DATA_W + 2);

    logic [1:0]       sync_q;
    logic             rx_s;
    logic             short_len;
    logic             has_extra;
    logic [IDX_W-1:0] nbits;
    logic             bit_stb;
    logic             bit_val;
    logic [IDX_W-1:0] bit_pos;
    logic             frame_done;
    logic             stop_ok;
    logic             rx_busy;
    logic [DATA_W-1:0] char_data;
    logic             char_extra;
    logic             parity_bad;
    logic             ready_pend;

    // Two-flop synchroniser on the asynchronous line, idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rx_line};
    end

    // Frame length from the selected format.
    always_comb begin
        rx_s      = sync_q[1];
        short_len = !mp_mode && !data_len8;
        has_extra = mp_mode || parity_en;
        nbits     = (short_len ? IDX_W'(DATA_W - 1) : IDX_W'(DATA_W))
                    + (has_extra ? IDX_W'(1) : IDX_W'(0));
    end

    uart_rx_sampler #(.OVS(OVS), .IDX_W(IDX_W)) u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_tick(sample_tick),
        .rx_s       (rx_s),
        .enable     (rx_enable),
        .nbits      (nbits),
        .bit_stb    (bit_stb),
        .bit_val    (bit_val),
        .bit_pos    (bit_pos),
        .frame_done (frame_done),
        .stop_ok    (stop_ok),
        .busy       (rx_busy)
    );

    uart_rx_assembler #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_assembler (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_stb    (bit_stb),
        .bit_val    (bit_val),
        .bit_pos    (bit_pos),
        .short_len  (short_len),
        .parity_odd (parity_odd),
        .char_data  (char_data),
        .char_extra (char_extra),
        .parity_bad (parity_bad)
    );

    uart_rx_status #(.DATA_W(DATA_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .stop_ok    (stop_ok),
        .char_data  (char_data),
        .char_extra (char_extra),
        .parity_bad (parity_bad),
        .mp_mode    (mp_mode),
        .parity_en  (parity_en),
        .data_read  (data_read),
        .err_clear  (err_clear),
        .irq_en     (rx_irq_en),
        .rx_data    (rx_data),
        .rx_adbit   (rx_adbit),
        .rx_ready   (rx_ready),
        .parity_err (parity_err),
        .frame_err  (frame_err),
        .overrun_err(overrun_err),
        .rx_irq     (rx_irq),
        .ready_pend (ready_pend)
    );
endmodule

// File: rtl/uart_rx_checker.sv
`timescale 1ns/1ps
// Module: uart_rx_checker
// Temporal properties of the receiver, attached to the top by bind.
// Assumes: connected by name to the top-level ports and internal nets.
module uart_rx_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_enable,
    input logic              mp_mode,
    input logic              data_len8,
    input logic              parity_en,
    input logic              data_read,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_ready,
    input logic              parity_err,
    input logic              frame_err,
    input logic              overrun_err,
    input logic              rx_irq,
    input logic              ready_pend,
    input logic              rx_busy
);
    AST_IRQ_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rx_ready); // R11
    AST_READ_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (data_read && rx_ready && !ready_pend) |=> !rx_ready); // R8
    AST_FERR_BEFORE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_err) |=> rx_ready); // R7
    AST_PERR_BEFORE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(parity_err) |=> rx_ready); // R7
    AST_OVERRUN_WHILE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_err) |-> rx_ready); // R9
    AST_NO_MP_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(parity_err) |-> $past(parity_en && !mp_mode)); // R5
    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> !rx_busy); // R12
    AST_SHORT_CHAR_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_ready) && !$past(mp_mode) && !$past(data_len8))
        |-> !rx_data[DATA_W-1]); // R3
endmodule

bind uart_mp_rx uart_rx_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/uart_mp_rx_bench.sv
`timescale 1ns/1ps
// Bench for uart_mp_rx: table-driven frames, then directed corner cases.
module uart_mp_rx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       rx_enable = 1'b0;
    logic       mp_mode = 1'b0, data_len8 = 1'b1, parity_en = 1'b0, parity_odd = 1'b0;
    logic       rx_irq_en = 1'b0, data_read = 1'b0, err_clear = 1'b0;
    logic [7:0] rx_data;
    logic       rx_adbit, rx_ready, parity_err, frame_err, overrun_err, rx_irq;

    int n_chk = 0;
    int n_fail = 0;
    logic prev_ferr = 1'b0, prev_perr = 1'b0, prev_rdy = 1'b0;
    logic seen_rise = 1'b0, ferr_at_rise = 1'b0, perr_at_rise = 1'b0;

    always #4 clk = ~clk;

    uart_mp_rx u_uart_mp_rx (
        .clk(clk), .rst_n(rst_n), .sample_tick(1'b1), .rx_line(rx_line),
        .rx_enable(rx_enable), .mp_mode(mp_mode), .data_len8(data_len8),
        .parity_en(parity_en), .parity_odd(parity_odd), .rx_irq_en(rx_irq_en),
        .data_read(data_read), .err_clear(err_clear), .rx_data(rx_data),
        .rx_adbit(rx_adbit), .rx_ready(rx_ready), .parity_err(parity_err),
        .frame_err(frame_err), .overrun_err(overrun_err), .rx_irq(rx_irq)
    );

    // Record the error flags one cycle before the ready flag's rising edge.
    always @(negedge clk) begin
        if (rx_ready && !prev_rdy && !seen_rise) begin
            seen_rise    <= 1'b1;
            ferr_at_rise <= prev_ferr;
            perr_at_rise <= prev_perr;
        end
        prev_ferr <= frame_err;
        prev_perr <= parity_err;
        prev_rdy  <= rx_ready;
    end

    // Vector: {mp, len8, par_en, odd, data[7:0], extra, stop}
    localparam logic [13:0] VEC [10] = '{
        {4'b0100, 8'h4D, 1'b0, 1'b1},
        {4'b0110, 8'hA5, 1'b0, 1'b1},
        {4'b0110, 8'hA5, 1'b1, 1'b1},
        {4'b0111, 8'h01, 1'b0, 1'b1},
        {4'b0111, 8'h01, 1'b1, 1'b1},
        {4'b0000, 8'hFF, 1'b0, 1'b1},
        {4'b0010, 8'h55, 1'b0, 1'b1},
        {4'b1010, 8'hC3, 1'b1, 1'b1},
        {4'b1100, 8'h3C, 1'b0, 1'b1},
        {4'b0100, 8'h00, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic mp, input logic l8, input logic pe,
                              input logic od, input logic [7:0] d,
                              input logic ex, input logic st);
        int nd;
        mp_mode = mp; data_len8 = l8; parity_en = pe; parity_odd = od;
        nd = (mp || l8) ? 8 : 7;
        rx_line = 1'b0; tick(16);
        for (int i = 0; i < nd; i++) begin
            rx_line = d[i]; tick(16);
        end
        if (mp || pe) begin
            rx_line = ex; tick(16);
        end
        rx_line = st; tick(16);
        rx_line = 1'b1; tick(8);
    endtask

    task automatic pulse_read();
        data_read = 1'b1; tick(1); data_read = 1'b0; tick(1);
    endtask

    task automatic pulse_clear();
        err_clear = 1'b1; tick(1); err_clear = 1'b0; tick(1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(1);
        // Reset state
        chk("R8 reset ready", {15'd0, rx_ready}, 16'd0);
        chk("R10 reset errors", {13'd0, parity_err, frame_err, overrun_err}, 16'd0);
        chk("R11 reset irq", {15'd0, rx_irq}, 16'd0);
        rx_enable = 1'b1;
        tick(4);

        // Table walk: R1, R3, R4, R5, R6, R8
        for (int v = 0; v < 10; v++) begin
            logic mp, l8, pe, od, ex, st, ep, ef, ea;
            logic [7:0] d, ed;
            {mp, l8, pe, od, d, ex, st} = VEC[v];
            ed = (mp || l8) ? d : {1'b0, d[6:0]};
            ea = mp ? ex : 1'b0;
            ep = !mp && pe && ((^ed) ^ ex ^ od);
            ef = !st;
            send_frame(mp, l8, pe, od, d, ex, st);
            chk("R1 ready after frame", {15'd0, rx_ready}, 16'd1);
            chk("R1 R3 data", {8'd0, rx_data}, {8'd0, ed});
            chk("R5 marker bit", {15'd0, rx_adbit}, {15'd0, ea});
            chk("R4 parity flag", {15'd0, parity_err}, {15'd0, ep});
            chk("R6 framing flag", {15'd0, frame_err}, {15'd0, ef});
            chk("R9 no overrun", {15'd0, overrun_err}, 16'd0);
            chk("R11 irq disabled", {15'd0, rx_irq}, 16'd0);
            pulse_read();
            chk("R8 read clears ready", {15'd0, rx_ready}, 16'd0);
            chk("R8 read keeps errors", {14'd0, parity_err, frame_err}, {14'd0, ep, ef});
            pulse_clear();
            chk("R10 clear errors", {13'd0, parity_err, frame_err, overrun_err}, 16'd0);
        end

        // R2: short glitch is ignored
        mp_mode = 1'b0; data_len8 = 1'b1; parity_en = 1'b0;
        rx_line = 1'b0; tick(4); rx_line = 1'b1; tick(200);
        chk("R2 glitch no char", {15'd0, rx_ready}, 16'd0);

        // R12: disabled receiver ignores a frame
        rx_enable = 1'b0;
        send_frame(1'b0, 1'b1, 1'b0, 1'b0, 8'h5A, 1'b0, 1'b1);
        rx_enable = 1'b1; tick(4);
        chk("R12 disabled no char", {15'd0, rx_ready}, 16'd0);

        // R9: two frames without a read
        send_frame(1'b0, 1'b1, 1'b0, 1'b0, 8'h11, 1'b0, 1'b1);
        chk("R9 no overrun yet", {15'd0, overrun_err}, 16'd0);
        send_frame(1'b0, 1'b1, 1'b0, 1'b0, 8'h22, 1'b0, 1'b1);
        chk("R9 overrun set", {15'd0, overrun_err}, 16'd1);
        chk("R9 data overwritten", {8'd0, rx_data}, 16'h0022);
        pulse_read(); pulse_clear();
        chk("R10 overrun cleared", {15'd0, overrun_err}, 16'd0);

        // R11: interrupt follows ready when enabled
        rx_irq_en = 1'b1;
        send_frame(1'b0, 1'b1, 1'b0, 1'b0, 8'h96, 1'b0, 1'b1);
        chk("R11 irq raised", {15'd0, rx_irq}, 16'd1);
        pulse_read();
        chk("R11 irq dropped", {15'd0, rx_irq}, 16'd0);
        rx_irq_en = 1'b0;

        // R7: framing error visible before ready
        seen_rise = 1'b0;
        send_frame(1'b0, 1'b1, 1'b0, 1'b0, 8'h81, 1'b0, 1'b0);
        chk("R7 ready rose", {15'd0, seen_rise}, 16'd1);
        chk("R7 frame err before ready", {15'd0, ferr_at_rise}, 16'd1);
        pulse_read(); pulse_clear();

        // R7: parity error visible before ready
        seen_rise = 1'b0;
        send_frame(1'b0, 1'b1, 1'b1, 1'b0, 8'h03, 1'b1, 1'b1);
        chk("R7 parity err before ready", {15'd0, perr_at_rise}, 16'd1);
        pulse_read(); pulse_clear();

        // R6: after break, a normal frame is received
        send_frame(1'b0, 1'b1, 1'b0, 1'b0, 8'hE7, 1'b0, 1'b1);
        chk("R6 recovery data", {8'd0, rx_data}, 16'h00E7);
        chk("R6 recovery no ferr", {15'd0, frame_err}, 16'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule